// File: doc/BRIEF.md
# Two-Bank Programmable Logic Element Array

This block is a small reconfigurable logic fabric of sixteen identical cells. The cells form two banks of eight. Each cell evaluates a two-input truth table and drives one output pin, either straight from the table or through its own flip-flop. Each operand comes through a selector. Operand A is either a bit that software writes or the output of a chosen cell in the same bank. Operand B is either the cell's own input pin or the output of another chosen cell in the same bank. Two fixed links carry a signal from the last cell of each bank to the first cell of the other bank. These links close the sixteen cells into one ring.

Software sets up the fabric through a plain memory-mapped port with a write enable, a byte address and combinational read data. Each cell has an 11-bit control word. A 16-bit word supplies the software operand bits. A read-only word returns the current output of every cell. All state uses one clock and a synchronous active-high reset.

Top module: `logic_cell_fabric`

## Requirements
- R1: While reset is high at a clock edge, every control word, the software operand word and every cell flip-flop clear to zero. After that edge, all pins read 0, and every control word and the operand word read back as 0.
- R2: Cell n's control word sits at byte offset 4·n (0x00–0x3C) and holds bits 10:0 of the write data. Bits 31:11 read as zero. Bits 10:9 select the A-side neighbour, bits 8:7 the B-side neighbour, bit 6 the A source, bit 5 the B source, bits 4:1 the truth table and bit 0 the flip-flop bypass.
- R3: Truth-table bit {A,B} (index 2·A+B) is the cell result. For example, 0001 is NOR, 0110 XOR, 1000 AND, 1010 passes B, 1100 passes A, 1110 OR, 0000 gives 0 and 1111 gives 1.
- R4: With bit 6 set, operand A is the selected neighbour output. With bit 6 clear, A is bit n of the software operand word.
- R5: With bit 5 set, operand B is input pin n. With bit 5 clear, B is the selected B-side neighbour output.
- R6: With bit 0 set, pin n follows the cell result in the same cycle. With bit 0 clear, pin n shows the result captured at the previous clock edge.
- R7: Let j be cell n's position within its bank (n mod 8). A-side select values 1, 2 and 3 pick the cells at positions j+1, j+2 and j+3 (mod 8) of the same bank. Select value 0 picks position j−1 for every cell except the first cell of a bank.
- R8: B-side select values 0, 1, 2 and 3 pick the cells at positions j+4, j+5, j+6 and j+7 (mod 8) of the same bank.
- R9: A-side select value 0 on cell 0 takes the output of cell 15. On cell 8 it takes the output of cell 7.
- R10: The software operand word is read/write at offset 0x40 (bits 15:0, upper bits read 0). The output word at offset 0x44 is read-only: a write there changes no state and no pin. Unmapped offsets read 0.
- R11: Reading offset 0x44 returns all sixteen cell outputs in bits 15:0, equal to the output pins, with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, taken at the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| pinIn | input | 16 | One external input pin per cell |
| pinOut | output | 16 | One output pin per cell |

## Verification
The truth table is tried exhaustively. All sixteen codes are driven with all four operand pairs, using the software bit and the pin so that a wrong table index stands out. Each A-side and B-side select value is swept with a single constant-one source cell, which shows whether the right neighbour and bank are reached. A token sent round a ring of registered cells must pass both cross-bank links, one cycle per cell; this separates registered timing from bypass timing. Random configurations restricted to loop-free bypass, with random pins and operand words, mix all paths against a bench model.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

  // Default geometry of the fabric
  localparam int NUM_CELLS = 16;
  localparam int BANK_SIZE = 8;
  localparam int CFG_W     = 11;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = $clog2(NUM_CELLS);

  // Control word field positions (the cell decodes these)
  localparam int F_BYPASS = 0;
  localparam int F_LUT_LO = 1;
  localparam int F_BSRC   = 5;
  localparam int F_ASRC   = 6;
  localparam int F_BSEL   = 7;
  localparam int F_ASEL   = 9;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic              cfgWr;
    logic              dinWr;
    logic [SEL_W-1:0]  cellSel;
    logic [DATA_W-1:0] wrData;
  } strobe_t;

endpackage

// File: rtl/lcf_cell.sv
module lcf_cell
  import lcf_pkg::*;
#(
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfgWord,
  input  logic [3:0]    aNeighbours,
  input  logic [3:0]    bNeighbours,
  input  logic          swBit,
  input  logic          pinBit,
  output logic          cellOut
);

  logic [1:0] aSel;
  logic [1:0] bSel;
  logic [3:0] truthTable;
  logic       aNbr;
  logic       bNbr;
  logic       opA;
  logic       opB;
  logic       lutVal;
  logic       heldVal;

  assign aSel       = cfgWord[F_ASEL +: 2];
  assign bSel       = cfgWord[F_BSEL +: 2];
  assign truthTable = cfgWord[F_LUT_LO +: 4];

  assign aNbr = aNeighbours[aSel];
  assign bNbr = bNeighbours[bSel];

  // Operand A: neighbour or software bit; operand B: pin or neighbour
  assign opA = cfgWord[F_ASRC] ? aNbr : swBit;
  assign opB = cfgWord[F_BSRC] ? pinBit : bNbr;

  assign lutVal = truthTable[{opA, opB}];

  always_ff @(posedge clk) begin
    if (rst) heldVal <= 1'b0;
    else     heldVal <= lutVal;
  end

  assign cellOut = cfgWord[F_BYPASS] ? lutVal : heldVal;

endmodule

// File: rtl/lcf_datapath.sv
module lcf_datapath
  import lcf_pkg::*;
#(
  parameter int N  = NUM_CELLS,
  parameter int BS = BANK_SIZE,
  parameter int CW = CFG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             stb,
  input  logic [N-1:0]        pinIn,
  output logic [N-1:0][CW-1:0] cfgWords,
  output logic [N-1:0]        dinWord,
  output logic [N-1:0]        cellOuts
);

  // Software operand word
  always_ff @(posedge clk) begin
    if (rst)            dinWord <= '0;
    else if (stb.dinWr) dinWord <= stb.wrData[N-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int BASE    = (i / BS) * BS;
    localparam int POS     = i % BS;
    // First cell of a bank reaches back to the last cell of the previous bank
    localparam int PREV    = (POS == 0) ? ((BASE + N - 1) % N) : (i - 1);

    logic [3:0] aNbrs;
    logic [3:0] bNbrs;

    always_ff @(posedge clk) begin
      if (rst)
        cfgWords[i] <= '0;
      else if (stb.cfgWr && (stb.cellSel == SEL_W'(i)))
        cfgWords[i] <= stb.wrData[CW-1:0];
    end

    assign aNbrs[0] = cellOuts[PREV];
    for (genvar k = 1; k < 4; k++) begin : g_anbr
      assign aNbrs[k] = cellOuts[BASE + ((POS + k) % BS)];
    end
    for (genvar k = 0; k < 4; k++) begin : g_bnbr
      assign bNbrs[k] = cellOuts[BASE + ((POS + 4 + k) % BS)];
    end

    lcf_cell #(.CW(CW)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .cfgWord    (cfgWords[i]),
      .aNeighbours(aNbrs),
      .bNeighbours(bNbrs),
      .swBit      (dinWord[i]),
      .pinBit     (pinIn[i]),
      .cellOut    (cellOuts[i])
    );
  end

endmodule

// File: rtl/lcf_ctrl.sv
module lcf_ctrl
  import lcf_pkg::*;
#(
  parameter int N  = NUM_CELLS,
  parameter int CW = CFG_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                 regWrEn,
  input  logic [AW-1:0]        regAddr,
  input  logic [DW-1:0]        regWrData,
  input  logic [N-1:0][CW-1:0] cfgWords,
  input  logic [N-1:0]         dinWord,
  input  logic [N-1:0]         cellOuts,
  output strobe_t              stb,
  output logic [DW-1:0]        regRdData
);

  localparam int IDX_W = AW - 2;
  localparam logic [IDX_W-1:0] DIN_IDX = IDX_W'(N);
  localparam logic [IDX_W-1:0] OUT_IDX = IDX_W'(N + 1);
  localparam logic [IDX_W-1:0] CFG_END = IDX_W'(N);

  logic [IDX_W-1:0] wordIdx;
  logic             isCfg;

  assign wordIdx = regAddr[AW-1:2];
  assign isCfg   = wordIdx < CFG_END;

  always_comb begin
    stb         = '0;
    stb.cfgWr   = regWrEn && isCfg;
    stb.dinWr   = regWrEn && (wordIdx == DIN_IDX);
    stb.cellSel = wordIdx[SEL_W-1:0];
    stb.wrData  = regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (isCfg)
      regRdData[CW-1:0] = cfgWords[wordIdx[SEL_W-1:0]];
    else if (wordIdx == DIN_IDX)
      regRdData[N-1:0] = dinWord;
    else if (wordIdx == OUT_IDX)
      regRdData[N-1:0] = cellOuts;
  end

endmodule

// File: rtl/logic_cell_fabric.sv
module logic_cell_fabric
  import lcf_pkg::*;
#(
  parameter int N  = NUM_CELLS,
  parameter int BS = BANK_SIZE,
  parameter int CW = CFG_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic [N-1:0]  pinIn,
  output logic [N-1:0]  pinOut
);

  strobe_t               stb;
  logic [N-1:0][CW-1:0]  cfgWords;
  logic [N-1:0]          dinWord;
  logic [N-1:0]          cellOuts;

  lcf_ctrl #(.N(N), .CW(CW), .AW(AW), .DW(DW)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .cfgWords (cfgWords),
    .dinWord  (dinWord),
    .cellOuts (cellOuts),
    .stb      (stb),
    .regRdData(regRdData)
  );

  lcf_datapath #(.N(N), .BS(BS), .CW(CW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .pinIn   (pinIn),
    .cfgWords(cfgWords),
    .dinWord (dinWord),
    .cellOuts(cellOuts)
  );

  assign pinOut = cellOuts;

endmodule

// File: rtl/lcf_checker.sv
module lcf_checker #(
  parameter int N  = 16,
  parameter int CW = 11,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [AW-1:0]        regAddr,
  input logic                 regWrEn,
  input logic [DW-1:0]        regWrData,
  input logic [DW-1:0]        regRdData,
  input logic [N-1:0]         pinOut,
  input logic [N-1:0][CW-1:0] cfgWords,
  input logic [N-1:0]         dinWord
);

  localparam int IDX_W = AW - 2;
  localparam logic [IDX_W-1:0] CFG_END = IDX_W'(N);
  localparam logic [IDX_W-1:0] OUT_IDX = IDX_W'(N + 1);

  logic [IDX_W-1:0] idx;
  assign idx = regAddr[AW-1:2];

  // R1: the cycle after a reset edge shows all pins low
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (pinOut == '0));

  // R2: reserved bits of a control word read as zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (idx < CFG_END) |-> (regRdData[DW-1:CW] == '0));

  // R2: a write to cell 0's word lands in its stored bits
  p_cfg_store_r2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && idx == '0) |=> (cfgWords[0] == $past(regWrData[CW-1:0])));

  // R10: a write to the read-only output word leaves the operand word alone
  p_out_ro_r10: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && idx == OUT_IDX) |=> (dinWord == $past(dinWord)));

  // R11: the output word mirrors the pins
  p_pin_readback_r11: assert property (@(posedge clk) disable iff (rst)
    (idx == OUT_IDX) |-> (regRdData[N-1:0] == pinOut));

endmodule

bind logic_cell_fabric lcf_checker #(.N(N), .CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .pinOut   (pinOut),
  .cfgWords (cfgWords),
  .dinWord  (dinWord)
);

// File: tb/logic_cell_fabric_tb.sv
`timescale 1ns/10ps
module logic_cell_fabric_tb;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;

  int checks = 0;
  int errors = 0;

  // Bench model state
  bit [10:0] mCfg [N];
  bit [15:0] mDin;
  bit [15:0] mQ;

  always #2 clk = ~clk;

  logic_cell_fabric u_dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn), .pinOut(pinOut)
  );

  function automatic bit cellF(int n, bit [15:0] o);
    int base = (n / 8) * 8;
    int pos  = n % 8;
    int prev = (pos == 0) ? ((base + N - 1) % N) : (n - 1);
    int s0   = int'(mCfg[n][10:9]);
    int s1   = int'(mCfg[n][8:7]);
    int srcA = (s0 == 0) ? prev : base + ((pos + s0) % 8);
    int srcB = base + ((pos + 4 + s1) % 8);
    bit a    = mCfg[n][6] ? o[srcA] : mDin[n];
    bit b    = mCfg[n][5] ? pinIn[n] : o[srcB];
    bit [3:0] tt = mCfg[n][4:1];
    return tt[{a, b}];
  endfunction

  function automatic bit [15:0] evalOut();
    bit [15:0] o = mQ;
    for (int it = 0; it < N + 1; it++)
      for (int n = 0; n < N; n++)
        o[n] = mCfg[n][0] ? cellF(n, o) : mQ[n];
    return o;
  endfunction

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle with an optional register write; model steps alongside
  task automatic stepCycle(bit wr, logic [7:0] addr, logic [31:0] data);
    bit [15:0] o, nxt;
    int idx;
    regWrEn = wr; regAddr = addr; regWrData = data;
    o = evalOut();
    for (int n = 0; n < N; n++) nxt[n] = cellF(n, o);
    @(posedge clk);
    mQ = nxt;
    idx = int'(addr[7:2]);
    if (wr) begin
      if (idx < N) mCfg[idx] = data[10:0];
      else if (idx == N) mDin = data[15:0];
    end
    @(negedge clk);
    regWrEn = 1'b0;
    #0.5;
  endtask

  task automatic writeCfg(int n, logic [31:0] v);
    stepCycle(1'b1, 8'(n * 4), v);
  endtask

  task automatic writeDin(logic [15:0] v);
    stepCycle(1'b1, 8'h40, {16'h0, v});
  endtask

  task automatic checkOut(string tag);
    bit [15:0] e;
    regAddr = 8'h44;
    #0.1;
    e = evalOut();
    report(tag, {16'h0, pinOut}, {16'h0, e});
    report("R11", regRdData, {16'h0, e});
  endtask

  task automatic checkRead(logic [7:0] addr, logic [31:0] exp, string tag);
    regAddr = addr;
    #0.1;
    report(tag, regRdData, exp);
  endtask

  task automatic clearAll();
    for (int n = 0; n < N; n++) writeCfg(n, 32'h0);
  endtask

  // Constant source cell: pin-driven B, software A, bypassed, table all-ones or zeros
  function automatic logic [31:0] constCfg(bit v);
    return v ? 32'h3F : 32'h21;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < N; n++) mCfg[n] = '0;
    mDin = '0; mQ = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;

    // R1: reset state
    report("R1", {16'h0, pinOut}, 32'h0);
    for (int n = 0; n < N; n++) begin
      checkRead(8'(n * 4), 32'h0, "R1");
      stepCycle(1'b0, 8'h0, 32'h0);
    end
    checkRead(8'h40, 32'h0, "R1");

    // R2: control word width and placement
    writeCfg(5, 32'hFFFF_FFFF);
    checkRead(8'h14, 32'h0000_07FF, "R2");
    writeCfg(12, 32'hABCD_E555);
    checkRead(8'h30, 32'h0000_0555, "R2");
    checkRead(8'h14, 32'h0000_07FF, "R2");
    checkOut("R2");
    clearAll();

    // R3: every table code against every operand pair (A=software bit, B=pin)
    for (int code = 0; code < 16; code++) begin
      writeCfg(3, 32'((code << 1) | 32'h21));
      for (int ab = 0; ab < 4; ab++) begin
        writeDin(16'(ab[1]) << 3);
        pinIn[3] = ab[0];
        checkOut("R3");
        if (pinOut[3] !== code[ab]) begin
          errors++;
          $display("FAIL R3 actual=%b expected=%b code=%0d ab=%0d", pinOut[3], code[ab], code, ab);
        end
        checks++;
      end
    end
    pinIn = '0;
    clearAll();

    // R4: A from software bit versus neighbour (cell 4 via select 1)
    writeCfg(4, constCfg(1'b0));
    writeDin(16'h0008);
    writeCfg(3, 32'h0000_0039);            // A source = software bit, table passes A
    checkOut("R4");
    writeCfg(3, 32'h0000_0279);            // A source = neighbour select 1
    checkOut("R4");
    writeCfg(4, constCfg(1'b1));
    writeDin(16'h0000);
    checkOut("R4");

    // R5: B from pin versus B-side neighbour (cell 7 via select 0)
    clearAll();
    writeCfg(7, constCfg(1'b1));
    writeCfg(3, 32'h0000_0035);            // B from pin, table passes B
    pinIn[3] = 1'b0;
    checkOut("R5");
    writeCfg(3, 32'h0000_0015);            // B from neighbour select 0
    checkOut("R5");
    writeCfg(7, constCfg(1'b0));
    checkOut("R5");
    pinIn = '0;

    // R6: registered versus bypassed timing on cell 6 (AND of software bit and pin)
    clearAll();
    writeCfg(6, 32'h0000_0030);
    writeDin(16'h0040);
    pinIn[6] = 1'b1;
    checkOut("R6");
    if (pinOut[6] !== 1'b0) begin errors++; $display("FAIL R6 actual=%b expected=0 before edge", pinOut[6]); end
    checks++;
    stepCycle(1'b0, 8'h0, 32'h0);
    checkOut("R6");
    if (pinOut[6] !== 1'b1) begin errors++; $display("FAIL R6 actual=%b expected=1 after edge", pinOut[6]); end
    checks++;
    writeCfg(6, 32'h0000_0031);
    pinIn[6] = 1'b0;
    checkOut("R6");
    if (pinOut[6] !== 1'b0) begin errors++; $display("FAIL R6 actual=%b expected=0 bypassed", pinOut[6]); end
    checks++;
    pinIn = '0;

    // R7: A-side neighbour selects on cell 2
    for (int s = 0; s < 4; s++) begin
      clearAll();
      for (int n = 0; n < N; n++) if (n != 2) writeCfg(n, constCfg(1'b0));
      writeCfg((s == 0) ? 1 : 2 + s, constCfg(1'b1));
      writeCfg(2, 32'((s << 9) | 32'h79));
      checkOut("R7");
      if (pinOut[2] !== 1'b1) begin errors++; $display("FAIL R7 actual=%b expected=1 sel=%0d", pinOut[2], s); end
      checks++;
    end

    // R8: B-side neighbour selects on cell 10
    for (int s = 0; s < 4; s++) begin
      clearAll();
      for (int n = 0; n < N; n++) if (n != 10) writeCfg(n, constCfg(1'b0));
      writeCfg(8 + ((2 + 4 + s) % 8), constCfg(1'b1));
      writeCfg(10, 32'((s << 7) | 32'h15));
      checkOut("R8");
      if (pinOut[10] !== 1'b1) begin errors++; $display("FAIL R8 actual=%b expected=1 sel=%0d", pinOut[10], s); end
      checks++;
    end

    // R9: cross-bank links, direct then as a registered ring
    clearAll();
    writeCfg(15, constCfg(1'b1));
    writeCfg(7, constCfg(1'b0));
    writeCfg(0, 32'h0000_0059);
    writeCfg(8, 32'h0000_0059);
    checkOut("R9");
    if (pinOut[0] !== 1'b1 || pinOut[8] !== 1'b0) begin
      errors++; $display("FAIL R9 actual=%b%b expected=10", pinOut[0], pinOut[8]);
    end
    checks++;
    clearAll();
    for (int n = 1; n < N; n++) writeCfg(n, 32'h0000_0058);
    writeCfg(0, 32'h0000_007C);            // A from cell 15, OR with pin 0
    pinIn[0] = 1'b1;
    stepCycle(1'b0, 8'h0, 32'h0);
    pinIn[0] = 1'b0;
    for (int c = 0; c < 20; c++) begin
      checkOut("R9");
      stepCycle(1'b0, 8'h0, 32'h0);
    end

    // Random mixes with loop-free bypass
    for (int r = 0; r < 40; r++) begin
      for (int n = 0; n < N; n++) begin
        logic [31:0] v = $urandom & 32'h7FF;
        if (!(v[6] == 1'b0 && v[5] == 1'b1)) v[0] = 1'b0;
        writeCfg(n, v);
      end
      writeDin(16'($urandom));
      for (int k = 0; k < 6; k++) begin
        pinIn = 16'($urandom);
        checkOut("R3");
        stepCycle(1'b0, 8'h0, 32'h0);
      end
    end

    // R10: operand word readback, output word read-only, unmapped reads
    writeDin(16'hA5C3);
    checkRead(8'h40, 32'h0000_A5C3, "R10");
    checkOut("R10");
    stepCycle(1'b1, 8'h44, 32'hFFFF_FFFF);
    checkRead(8'h40, 32'h0000_A5C3, "R10");
    checkOut("R10");
    stepCycle(1'b1, 8'h48, 32'hFFFF_FFFF);
    checkRead(8'h48, 32'h0, "R10");
    checkRead(8'h7C, 32'h0, "R10");
    checkOut("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule